// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps the contents of an asynchronous DRAM alive. An interval timer sets the spacing of refresh requests so that the required number of refreshes is spread evenly over the retention period. A parameter picks one of two configurations: 2048 rows refreshed within every 32 ms, or 4096 rows refreshed within every 64 ms. Each request is offered to the access sequencer through a request/grant handshake. Once the request is granted, the scheduler takes over the row and column strobes and runs one refresh cycle on its own.

In the default mode the cycle brings the column strobe low first and then drops the row strobe. The memory takes the row from its own internal counter, so the scheduler does not drive the address bus. No data moves during the cycle: the output-enable and write-enable strobes stay inactive. In the optional row-strobe-only mode the column strobe stays high. The scheduler then drives the row address itself from an internal counter that wraps after the last row. Requests that cannot be served at once are held in a small pending counter of depth two. A sticky error flag records any request lost beyond that depth.

Top module: `dram_refresh_sched`

## Requirements
- R1: The request interval is REFI = floor(CLK_KHZ*RET_MS/ROWS) clocks, with ROWS=2048 and RET_MS=32 when MODE_4K=0, and ROWS=4096 and RET_MS=64 when MODE_4K=1. The first req_o appears exactly REFI clocks after reset release. With the grant always given, at least ROWS row-strobe falls occur within CLK_KHZ*RET_MS clocks.
- R2: In the default mode, cas_n_o falls at the clock edge that accepts the grant. ras_n_o falls T_SU clocks later, while cas_n_o is still low. cas_n_o stays low for T_SU+T_RAS clocks in total.
- R3: At most two requests are held pending. A further interval expiry while two are pending sets ovf_o, which stays set until reset.
- R4: req_o is high only while a request is pending and no cycle is running. A cycle starts at the edge where req_o and gnt_i are both high. req_o stays low while busy_o is high.
- R5: ras_n_o stays low for exactly T_RAS clocks in every refresh cycle.
- R6: After ras_n_o rises, both strobes stay high. busy_o remains high for T_RP more clocks, so busy_o is high for T_SU+T_RAS+T_RP clocks per cycle.
- R7: oe_n_o and we_n_o are always high. In the default mode addr_oe_o stays low, so the address bus is left undriven.
- R8: In row-strobe-only mode, cas_n_o stays high. addr_oe_o is high during the setup and active phases. At the k-th row-strobe fall after reset, addr_o equals k mod ROWS (counting from 0), so it wraps from ROWS-1 to 0.
- R9: During and straight after reset: ras_n_o=1, cas_n_o=1, req_o=0, busy_o=0, ovf_o=0.
- R10: Each started cycle consumes one pending request. After two postponed requests, two granted cycles empty the counter and req_o stays low until the next interval expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| req_o | output | 1 | Refresh request to the access sequencer |
| busy_o | output | 1 | Refresh cycle in progress, including precharge |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| oe_n_o | output | 1 | Output enable, held inactive |
| we_n_o | output | 1 | Write enable, held inactive |
| addr_o | output | ROW_W | Row address (row-strobe-only mode) |
| addr_oe_o | output | 1 | Address bus drive enable |
| ovf_o | output | 1 | Sticky pending-request overflow |

## Verification
A wrong interval count shows on req_o within the first REFI clocks after reset, and the effect adds up over a full retention window in the refresh count. A wrong phase counter in the cycle controller shows at once in the length of the strobe-low and busy pulses of the first granted cycle. A wrong pending count shows one interval later, either as a spurious or missing ovf_o or as req_o staying high after the queue has been drained. A wrong row counter shows on addr_o at the next row-strobe fall, and a fault at the wrap shows after ROWS refreshes.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACT   = 2'd2,
    ST_PRE   = 2'd3
  } ref_state_e;
endpackage

// File: rtl/dram_ref_interval.sv
module dram_ref_interval #(
  parameter int REFI = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(REFI + 1);
  localparam logic [CW-1:0] LAST = CW'(REFI - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_ref_pending.sv
module dram_ref_pending #(
  parameter int MAX_PEND = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic pend_nz_o,
  output logic ovf_o
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] FULL = PW'(MAX_PEND);

  logic [PW-1:0] pend_q;
  logic          ovf_q;

  assign pend_nz_o = (pend_q != '0);
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10: begin
          if (pend_q == FULL) ovf_q  <= 1'b1;
          else                pend_q <= pend_q + 1'b1;
        end
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end
endmodule

// File: rtl/dram_ref_cycle.sv
module dram_ref_cycle
  import dram_ref_pkg::*;
#(
  parameter int T_SU     = 2,
  parameter int T_RAS    = 3,
  parameter int T_RP     = 3,
  parameter bit RAS_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic addr_oe_o,
  output logic row_adv_o
);
  localparam int TMAX = (T_SU > T_RAS) ? ((T_SU > T_RP) ? T_SU : T_RP)
                                       : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [TW-1:0] SU_LD  = TW'(T_SU - 1);
  localparam logic [TW-1:0] RAS_LD = TW'(T_RAS - 1);
  localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 1);

  ref_state_e    st_q;
  logic [TW-1:0] tmr_q;
  logic          tmr_done;

  assign tmr_done = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SETUP;
          tmr_q <= SU_LD;
        end
        ST_SETUP: begin
          if (tmr_done) begin
            st_q  <= ST_ACT;
            tmr_q <= RAS_LD;
          end else tmr_q <= tmr_q - 1'b1;
        end
        ST_ACT: begin
          if (tmr_done) begin
            st_q  <= ST_PRE;
            tmr_q <= RP_LD;
          end else tmr_q <= tmr_q - 1'b1;
        end
        ST_PRE: begin
          if (tmr_done) st_q <= ST_IDLE;
          else          tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign ras_n_o   = (st_q != ST_ACT);
  assign row_adv_o = (st_q == ST_ACT) && tmr_done;

  generate
    if (RAS_ONLY) begin : g_ras_only
      assign cas_n_o   = 1'b1;
      assign addr_oe_o = (st_q == ST_SETUP) || (st_q == ST_ACT);
    end else begin : g_cbr
      // column strobe leads the row strobe and holds through the active phase
      assign cas_n_o   = !((st_q == ST_SETUP) || (st_q == ST_ACT));
      assign addr_oe_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dram_ref_row.sv
module dram_ref_row #(
  parameter int ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (adv_i) row_o <= row_o + 1'b1;  // natural wrap at 2**ROW_W
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_KHZ  = 50000,
  parameter bit MODE_4K  = 1'b0,
  parameter bit RAS_ONLY = 1'b0,
  parameter int T_SU     = 2,
  parameter int T_RAS    = 3,
  parameter int T_RP     = 3,
  parameter int ROW_W    = MODE_4K ? 12 : 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             addr_oe_o,
  output logic             ovf_o
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int RET_MS = MODE_4K ? 64 : 32;
  localparam int REFI   = (CLK_KHZ * RET_MS) / ROWS;

  logic tick, pend_nz, idle, start, row_adv;
  logic [ROW_W-1:0] row;

  dram_ref_interval #(.REFI(REFI)) u_interval (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  dram_ref_pending #(.MAX_PEND(2)) u_pending (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .take_i(start),
    .pend_nz_o(pend_nz), .ovf_o(ovf_o)
  );

  dram_ref_cycle #(
    .T_SU(T_SU), .T_RAS(T_RAS), .T_RP(T_RP), .RAS_ONLY(RAS_ONLY)
  ) u_cycle (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .idle_o(idle),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .addr_oe_o(addr_oe_o),
    .row_adv_o(row_adv)
  );

  dram_ref_row #(.ROW_W(ROW_W)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(row_adv), .row_o(row)
  );

  assign req_o  = pend_nz && idle;
  assign start  = req_o && gnt_i;
  assign busy_o = !idle;
  assign oe_n_o = 1'b1;
  assign we_n_o = 1'b1;
  assign addr_o = RAS_ONLY ? row : '0;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int T_RAS    = 3,
  parameter int T_RP     = 3,
  parameter bit RAS_ONLY = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_o,
  input logic busy_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic addr_oe_o,
  input logic ovf_o
);
  localparam logic [15:0] RAS_W = 16'(T_RAS);
  localparam logic [15:0] RP_W  = 16'(T_RP);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= RP_W;
    end else begin
      lo_cnt <= ras_n_o ? '0 : ((lo_cnt == 16'hffff) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n_o ? '0 : ((hi_cnt == 16'hffff) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  assert_ras_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt == RAS_W));

  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= RP_W));

  assert_idle_strobes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_n_o && cas_n_o));

  assert_req_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !busy_o);

  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovf_o) |-> ovf_o);

  generate
    if (RAS_ONLY) begin : g_ro
      assert_cas_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ras_n_o |-> (cas_n_o && addr_oe_o));
    end else begin : g_cbr
      assert_cas_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
      assert_no_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !addr_oe_o);
    end
  endgenerate
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .T_RAS(T_RAS), .T_RP(T_RP), .RAS_ONLY(RAS_ONLY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o), .busy_o(busy_o),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .addr_oe_o(addr_oe_o), .ovf_o(ovf_o)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int KHZ = 2000, SU = 2, RAS = 5, RP = 3;
  localparam int RO_KHZ = 1000, RO_SU = 1, RO_RAS = 4, RO_RP = 3;

  function automatic int exp_refi(int khz, bit m4k);
    return (khz * (m4k ? 64 : 32)) / (m4k ? 4096 : 2048);
  endfunction
  function automatic int exp_row(int k, int rows);
    return k % rows;
  endfunction

  localparam int REFI = (KHZ * 32) / 2048;

  logic clk = 1'b0, rst_n = 1'b0, rst_ro_n = 1'b0;
  logic gnt_man = 1'b0, auto_gnt = 1'b0;
  logic gnt, req, busy, ras_n, cas_n, oe_n, we_n, aoe, ovf;
  logic [10:0] addr;
  logic gnt_ro, req_ro, busy_ro, ras_ro, cas_ro, oe_ro, we_ro, aoe_ro, ovf_ro;
  logic [11:0] addr_ro;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign gnt    = auto_gnt ? req : gnt_man;
  assign gnt_ro = req_ro;

  dram_refresh_sched #(.CLK_KHZ(KHZ), .MODE_4K(1'b0), .RAS_ONLY(1'b0),
    .T_SU(SU), .T_RAS(RAS), .T_RP(RP)) u_dram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_o(req), .busy_o(busy),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .oe_n_o(oe_n), .we_n_o(we_n),
    .addr_o(addr), .addr_oe_o(aoe), .ovf_o(ovf));

  dram_refresh_sched #(.CLK_KHZ(RO_KHZ), .MODE_4K(1'b1), .RAS_ONLY(1'b1),
    .T_SU(RO_SU), .T_RAS(RO_RAS), .T_RP(RO_RP)) u_dram_refresh_sched_ro (
    .clk_i(clk), .rst_ni(rst_ro_n), .gnt_i(gnt_ro), .req_o(req_ro), .busy_o(busy_ro),
    .ras_n_o(ras_ro), .cas_n_o(cas_ro), .oe_n_o(oe_ro), .we_n_o(we_ro),
    .addr_o(addr_ro), .addr_oe_o(aoe_ro), .ovf_o(ovf_ro));

  task automatic chk(string req_tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gnt_man = 1'b0; auto_gnt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // grant at the next negedge with req high, then measure the cycle shape
  task automatic grant_and_measure();
    int cas_first, ras_first, cas_lo, ras_lo, busy_hi, aoe_hi, strobe_bad, req_busy;
    while (!req) @(negedge clk);
    gnt_man = 1'b1;
    @(negedge clk);
    gnt_man = 1'b0;
    cas_first = -1; ras_first = -1; cas_lo = 0; ras_lo = 0;
    busy_hi = 0; aoe_hi = 0; strobe_bad = 0; req_busy = 0;
    for (int i = 0; i < SU + RAS + RP + 2; i++) begin
      if (!cas_n) begin cas_lo++; if (cas_first < 0) cas_first = i; end
      if (!ras_n) begin
        ras_lo++;
        if (ras_first < 0) ras_first = i;
        if (cas_n) strobe_bad++;
      end
      if (busy) busy_hi++;
      if (busy && req) req_busy++;
      if (aoe) aoe_hi++;
      if (!oe_n || !we_n) strobe_bad++;
      if (i < SU + RAS + RP - 1) @(negedge clk);
      else if (i < SU + RAS + RP + 1) @(negedge clk);
    end
    chk("R2 cas first index", cas_first, 0);
    chk("R2 ras fall offset", ras_first, SU);
    chk("R2 cas low length", cas_lo, SU + RAS);
    chk("R5 ras low length", ras_lo, RAS);
    chk("R6 busy length", busy_hi, SU + RAS + RP);
    chk("R4 req while busy", req_busy, 0);
    chk("R7 addr drive/strobes", aoe_hi + strobe_bad, 0);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int n, falls, k, bad, badcas;
    // R9 reset values
    repeat (2) @(negedge clk);
    chk("R9 reset ras_n", ras_n, 1);
    chk("R9 reset cas_n", cas_n, 1);
    chk("R9 reset req", req, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset ovf", ovf, 0);
    do_reset();

    // R1 first request time
    n = 0;
    while (!req && n < 4 * REFI) begin @(negedge clk); n++; end
    chk("R1 first request", n, exp_refi(KHZ, 1'b0));

    // R3 / R10 postponement and overflow
    while (n < 3 * REFI - 1) begin @(negedge clk); n++; end
    chk("R3 no ovf at two pending", ovf, 0);
    @(negedge clk); n++;
    chk("R3 ovf on third", ovf, 1);
    grant_and_measure();
    chk("R10 req after first drain", req, 1);
    grant_and_measure();
    chk("R10 req after second drain", req, 0);
    chk("R3 ovf sticky", ovf, 1);

    // random grant delays below the interval slack
    do_reset();
    for (int it = 0; it < 30; it++) begin
      int d;
      while (!req) @(negedge clk);
      d = int'($urandom % (REFI - (SU + RAS + RP) - 4));
      repeat (d) @(negedge clk);
      grant_and_measure();
    end
    chk("R3 no ovf with timely grants", ovf, 0);

    // R1 rate over one retention window, grant always given
    do_reset();
    auto_gnt = 1'b1;
    falls = 0;
    for (int c = 0; c < KHZ * 32; c++) begin
      logic prev;
      prev = ras_n;
      @(negedge clk);
      if (prev && !ras_n) falls++;
    end
    n_tests++;
    if (falls < 2048) begin
      n_fail++;
      $display("FAIL R1 refresh count: actual %0d expected >= 2048", falls);
    end
    auto_gnt = 1'b0;

    // R8 row-strobe-only mode, full wrap
    rst_ro_n = 1'b1;
    k = 0; bad = 0; badcas = 0;
    for (int c = 0; c < 4098 * exp_refi(RO_KHZ, 1'b1) + 40; c++) begin
      logic prev;
      prev = ras_ro;
      @(negedge clk);
      if (!cas_ro) badcas++;
      if (prev && !ras_ro) begin
        if (addr_ro != 12'(exp_row(k, 4096)) || !aoe_ro) begin
          if (bad == 0)
            $display("FAIL R8 row at refresh %0d: actual %0d expected %0d",
                     k, addr_ro, exp_row(k, 4096));
          bad++;
        end
        k++;
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
    chk("R8 cas stays high", badcas, 0);
    n_tests++;
    if (k < 4097) begin
      n_fail++;
      $display("FAIL R8 wrap reached: actual %0d expected >= 4097", k);
    end
    chk("R3 ro no ovf", ovf_ro, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule